// File: doc/BRIEF.md
# Register File with Write-Through Read Bypass

This block is the general-purpose register storage of a five-stage in-order pipeline. The decode stage reads two source operands through two combinational read ports. The write-back stage commits at most one result per cycle through a single synchronous write port. Storage is a bank of flip-flops, one word per architectural register.

When write-back commits to the same register that decode reads in that cycle, the read ports return the value being written and not the stale stored word. This matches a register file that writes early in the cycle and reads late. As a result, the write-back-to-decode dependency needs no separate forwarding network. Register 0 is hard-wired to zero. A synchronous reset clears every register.

The operand and result paths are fixed-timing pipeline taps, so they carry no valid/ready handshake. A write is qualified by its enable alone, and the reads are combinational and always available. Back-pressure does not apply to this block.

Top module: `regfile_bypass`

## Requirements
- R1: When `wr_en` is high at a rising clock edge and `rst` is low, the register at `wr_addr` (5-bit index, 32 registers of 32 bits) takes `wr_data`, and any later read of that index returns it until it is written again.
- R2: The two read ports are combinational and independent: each returns the word at its own address in the same cycle, and both may address the same register.
- R3: When `wr_en` is high and `wr_addr` equals a read address other than 0, that read port returns `wr_data` in the same cycle, before the edge that stores it.
- R4: When `wr_en` is low, no register changes and no read port shows `wr_data`, even if `wr_addr` matches the read address.
- R5: Index 0 always reads as zero on both ports. Writes to index 0 are discarded, and the bypass of R3 does not apply to it.
- R6: A rising edge with `rst` high clears all 32 registers to zero. Reset takes priority over a write in the same cycle.
- R7: A write changes only the addressed register. Every other register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_addr | input | 5 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_addr | input | 5 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable from write-back |
| wr_addr | input | 5 | Write register index |
| wr_data | input | 32 | Write data |

## Verification
The bench builds the block with its default parameters: 32-bit words and 32 registers, so the address width is 5. With these values, random addresses hit both the top index 31 and index 0 often. Random 5-bit indices also produce write/read address matches on either port, or on both ports at once, often enough to exercise the bypass alongside ordinary reads. Directed steps add the remaining corner cases: a write to index 0 with the bypass active, a matching address with the enable low, and a reset that lands in the same cycle as a write.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int unsigned RF_DATA_W = 32;
  localparam int unsigned RF_NREGS  = 32;
  localparam int unsigned RF_IDX_W  = $clog2(RF_NREGS);
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [NREGS-1:0] sel
);
  // index 0 never selected: the zero register has no storage
  for (genvar g = 0; g < NREGS; g++) begin : g_sel
    if (g == 0) begin : g_zero
      assign sel[g] = 1'b0;
    end else begin : g_live
      assign sel[g] = en && (idx == IDX_W'(g));
    end
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREGS  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NREGS-1:0]  sel,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q [NREGS]
);
  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == 0) begin : g_const
      assign q[g] = '0;
    end else begin : g_flop
      logic [DATA_W-1:0] word;
      always_ff @(posedge clk) begin
        if (rst)         word <= '0;
        else if (sel[g]) word <= din;
      end
      assign q[g] = word;
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREGS  = 32,
  parameter int unsigned IDX_W  = $clog2(NREGS)
) (
  input  logic [DATA_W-1:0] q [NREGS],
  input  logic [IDX_W-1:0]  addr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] data
);
  logic hit;
  assign hit = wr_en && (wr_addr == addr) && (addr != '0);

  always_comb begin
    if (addr == '0) data = '0;
    else if (hit)   data = wr_data;
    else            data = q[addr];
  end
endmodule

// File: rtl/regfile_bypass.sv
module regfile_bypass
  import regfile_pkg::*;
#(
  parameter int unsigned DATA_W = RF_DATA_W,
  parameter int unsigned NREGS  = RF_NREGS,
  localparam int unsigned IDX_W = $clog2(NREGS),
  localparam int unsigned NPORTS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  logic [NREGS-1:0]  wr_sel;
  logic [DATA_W-1:0] regs [NREGS];
  logic [IDX_W-1:0]  port_addr [NPORTS];
  logic [DATA_W-1:0] port_data [NPORTS];

  assign port_addr[0] = rd_a_addr;
  assign port_addr[1] = rd_b_addr;
  assign rd_a_data    = port_data[0];
  assign rd_b_data    = port_data[1];

  rf_wr_decode #(.NREGS(NREGS), .IDX_W(IDX_W)) u_dec (
    .en  (wr_en),
    .idx (wr_addr),
    .sel (wr_sel)
  );

  rf_storage #(.DATA_W(DATA_W), .NREGS(NREGS)) u_store (
    .clk (clk),
    .rst (rst),
    .sel (wr_sel),
    .din (wr_data),
    .q   (regs)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    rf_read_port #(.DATA_W(DATA_W), .NREGS(NREGS), .IDX_W(IDX_W)) u_rd (
      .q       (regs),
      .addr    (port_addr[p]),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .data    (port_data[p])
    );
  end
endmodule

// File: rtl/regfile_bypass_checker.sv
module regfile_bypass_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREGS  = 32,
  parameter int unsigned IDX_W  = $clog2(NREGS)
) (
  input logic              clk,
  input logic              rst,
  input logic [IDX_W-1:0]  rd_a_addr,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [IDX_W-1:0]  rd_b_addr,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [NREGS-1:0]  wr_sel
);
  AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (rst) (rd_a_addr == '0) |-> (rd_a_data == '0)); // R5
  AST_ZERO_REG_B: assert property (@(posedge clk) disable iff (rst) (rd_b_addr == '0) |-> (rd_b_data == '0)); // R5
  AST_BYPASS_A: assert property (@(posedge clk) disable iff (rst) (wr_en && wr_addr == rd_a_addr && rd_a_addr != '0) |-> (rd_a_data == wr_data)); // R3
  AST_BYPASS_B: assert property (@(posedge clk) disable iff (rst) (wr_en && wr_addr == rd_b_addr && rd_b_addr != '0) |-> (rd_b_data == wr_data)); // R3
  AST_WRITE_STICKS: assert property (@(posedge clk) disable iff (rst) (wr_en && wr_addr != '0) |=> (rd_a_addr != $past(wr_addr) || (wr_en && wr_addr == rd_a_addr) || rd_a_data == $past(wr_data))); // R1
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst) $onehot0(wr_sel)); // R7
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (wr_en || rd_a_data == '0)); // R6
endmodule

bind regfile_bypass regfile_bypass_checker #(.DATA_W(DATA_W), .NREGS(NREGS), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_a_addr (rd_a_addr),
  .rd_a_data (rd_a_data),
  .rd_b_addr (rd_b_addr),
  .rd_b_data (rd_b_data),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .wr_sel    (wr_sel)
);

// File: tb/regfile_bypass_tb.sv
`timescale 1ns/1ps
module regfile_bypass_tb;
  localparam int DW = 32;
  localparam int NR = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
  logic          wr_en = 1'b0;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] model [NR];

  always #2 clk = ~clk;

  regfile_bypass u_dut (
    .clk(clk), .rst(rst),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [DW-1:0] expect_rd(logic [AW-1:0] ra, logic we,
                                               logic [AW-1:0] wa, logic [DW-1:0] wd);
    if (ra == '0) return '0;                   // R5
    if (we && wa == ra) return wd;             // R3
    return model[ra];                          // R1, R4
  endfunction

  task automatic cmp(string tag, string port, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s port %s: actual=%h expected=%h", tag, port, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check combinational reads, model updates at posedge
  task automatic step(string tag, logic r, logic we, logic [AW-1:0] wa,
                      logic [DW-1:0] wd, logic [AW-1:0] ra, logic [AW-1:0] rb);
    @(negedge clk);
    rst = r; wr_en = we; wr_addr = wa; wr_data = wd;
    rd_a_addr = ra; rd_b_addr = rb;
    #1;
    if (!r) begin
      cmp(tag, "A", rd_a_data, expect_rd(ra, we, wa, wd));
      cmp(tag, "B", rd_b_data, expect_rd(rb, we, wa, wd));
    end
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < NR; i++) model[i] = '0;
    end else if (we && wa != '0) begin
      model[wa] = wd;
    end
  endtask

  task automatic read_all_zero(string tag);
    for (int i = 0; i < NR / 2; i++)
      step(tag, 1'b0, 1'b0, '0, '0, AW'(i), AW'(NR - 1 - i));
  endtask

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    void'($urandom(32'd1234));
    // R6: reset, including a write attempted while reset is high
    step("R6", 1'b1, 1'b0, '0, '0, '0, '0);
    step("R6", 1'b1, 1'b1, 5'd5, 32'hDEAD_BEEF, '0, '0);
    read_all_zero("R6");
    // R5: write to index 0 with both ports reading it
    step("R5", 1'b0, 1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0);
    step("R5", 1'b0, 1'b0, '0, '0, 5'd0, 5'd0);
    // R3: same-cycle bypass on both ports at the top index
    step("R3", 1'b0, 1'b1, 5'd31, 32'h1234_5678, 5'd31, 5'd31);
    step("R1", 1'b0, 1'b0, '0, '0, 5'd31, 5'd30);
    // R4: matching address with enable low shows stored value
    step("R4", 1'b0, 1'b0, 5'd31, 32'hAAAA_5555, 5'd31, 5'd31);
    step("R4", 1'b0, 1'b0, '0, '0, 5'd31, 5'd0);
    // R7: neighbours undisturbed
    step("R7", 1'b0, 1'b1, 5'd30, 32'h0BAD_F00D, 5'd29, 5'd31);
    step("R7", 1'b0, 1'b0, '0, '0, 5'd30, 5'd31);
    // random mix: R1/R2/R3/R4/R5/R7
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] wa, ra, rb;
      wa = AW'($urandom);
      ra = ($urandom % 4 == 0) ? wa : AW'($urandom);
      rb = ($urandom % 4 == 0) ? ra : AW'($urandom);
      step("R1/R2/R3", 1'b0, logic'($urandom % 3 != 0), wa, $urandom, ra, rb);
    end
    // R6: reset mid-run with a colliding write
    step("R6", 1'b1, 1'b1, 5'd9, 32'h5555_AAAA, '0, '0);
    read_all_zero("R6");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule